// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Sequencer

This block runs the external bus of an 8-bit processor whose low address byte shares pins with the data byte. The core hands it one request at a time: a cycle kind (opcode fetch, memory read, memory write, I/O read or I/O write), a 16-bit address and, for writes, a data byte. The sequencer then walks through its T-states. It drives the high address byte on dedicated pins. It time-shares the AD pins between the low address byte and the data. It pulses the address latch enable, lowers the read or write strobe, and sets the memory/I/O select and the two status lines so that external logic can tell which kind of cycle is running.

The first T-state puts the full address out with the latch enable high. From the second T-state on, the AD pins carry data. For an opcode fetch the core supplies the program counter as the address. The byte returned is caught in a data register and then moved into an instruction register. The fetch also gets a fourth T-state, flagged for the core's decoder. The other four cycle kinds end after three T-states. A one-cycle completion pulse marks the last T-state of every cycle, and the sequencer is idle again on the next clock.

Top module: `mcs_bus_seq`

## Requirements
- R1: While reset is applied, and for two clocks after it is released, the block is idle: busy, done, decode, ale and ad_oe are low, rd_n and wr_n are high, and addr_hi, ad_out, io_m, s1, s0, data_reg and instr_reg are all zero.
- R2: In idle, req_valid high with a legal kind (0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write) starts T1 on the next clock. busy is high from T1 through the last T-state. Requests presented while busy are ignored.
- R3: In T1, ale is high, addr_hi carries address bits 15..8, and ad_out carries address bits 7..0 with ad_oe high. ale is low in every other state. addr_hi holds the high byte for the whole cycle and is zero in idle.
- R4: After T1 the AD pins never carry the address. Read kinds release them (ad_oe low). Write kinds drive the write byte in T2 and T3. ad_out is zero whenever ad_oe is low.
- R5: io_m and {s1,s0} are driven for the whole cycle: fetch 0/11, memory read 0/10, memory write 0/01, I/O read 1/10, I/O write 1/01. In idle they are 0/00.
- R6: rd_n is low exactly during T2 of fetch, memory read and I/O read cycles, and high everywhere else.
- R7: wr_n is low exactly during T2 of memory write and I/O write cycles, and high everywhere else.
- R8: data_reg takes the value on ad_in at the clock that ends T2 of a read kind, and keeps its value at every other clock.
- R9: instr_reg takes data_reg at the clock that ends T3 of an opcode fetch only.
- R10: An opcode fetch has a T4 in which decode is high. The other kinds have no T4, and decode is low outside T4.
- R11: done is high for exactly the final T-state (T4 for a fetch, T3 otherwise), and the block is idle on the next clock.
- R12: A request whose kind is 5, 6 or 7 starts no cycle and leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 3 | Cycle kind code (0..4 legal) |
| req_addr | input | 16 | Cycle address (program counter for a fetch) |
| req_wdata | input | 8 | Write byte for write kinds |
| ad_in | input | 8 | Byte read from the AD pins |
| busy | output | 1 | A machine cycle is in progress |
| done | output | 1 | Final T-state of the cycle |
| decode | output | 1 | T4 of an opcode fetch |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Byte driven onto the AD pins |
| ad_oe | output | 1 | AD pin output enable |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | High for I/O, low for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| data_reg | output | 8 | Data register |
| instr_reg | output | 8 | Instruction register |

## Verification
The bench targets the hand-over of the AD pins at the T1/T2 boundary. A design that kept driving the address there, or drove write data in T1, would fight the memory or corrupt the latched address. ad_in changes on every clock, so a data register that captured one clock early or late, or captured during writes, shows a wrong byte. The bench also checks that the instruction register moves only on fetches and that the fetch gets its fourth T-state while the other kinds do not. A request held high through a busy cycle, and the illegal kind codes, test the idle-only acceptance. A design that re-armed mid-cycle or treated kinds 5..7 as cycles would start a spurious one.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  localparam logic [2:0] KIND_LAST = 3'd4;

  function automatic logic kind_legal(input logic [2:0] code);
    return code <= KIND_LAST;
  endfunction

  function automatic logic kind_reads(input kind_e k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic kind_writes(input kind_e k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic kind_io(input kind_e k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  // status pair {s1,s0}: fetch 11, read 10, write 01
  function automatic logic [1:0] kind_status(input kind_e k);
    logic [1:0] code;
    case (k)
      K_FETCH:       code = 2'b11;
      K_MRD, K_IORD: code = 2'b10;
      K_MWR, K_IOWR: code = 2'b01;
      default:       code = 2'b00;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/mcs_reset_sync.sv
module mcs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mcs_tstate_fsm.sv
module mcs_tstate_fsm
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output tstate_e           state,
  output kind_e             cur_kind,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);

  tstate_e state_q, state_d;
  logic    accept;

  assign accept = (state_q == TS_IDLE) && req_valid && kind_legal(req_kind);

  always_comb begin
    state_d = state_q;
    case (state_q)
      TS_IDLE: if (accept) state_d = TS_T1;
      TS_T1:   state_d = TS_T2;
      TS_T2:   state_d = TS_T3;
      TS_T3:   state_d = (cur_kind == K_FETCH) ? TS_T4 : TS_IDLE;
      TS_T4:   state_d = TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TS_IDLE;
    else        state_q <= state_d;
  end

  // request latch, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind  <= K_FETCH;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_kind  <= kind_e'(req_kind);
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/mcs_pin_drive.sv
module mcs_pin_drive
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  tstate_e           state,
  input  kind_e             cur_kind,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic              busy,
  output logic              done,
  output logic              decode,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0
);

  logic       active, is_rd, is_wr, data_phase;
  logic [1:0] status;

  assign active     = (state != TS_IDLE);
  assign is_rd      = kind_reads(cur_kind);
  assign is_wr      = kind_writes(cur_kind);
  assign data_phase = (state == TS_T2) || (state == TS_T3);
  assign status     = kind_status(cur_kind);

  always_comb begin
    busy    = active;
    ale     = (state == TS_T1);
    addr_hi = active ? cur_addr[ADDR_W-1:DATA_W] : '0;
    io_m    = active && kind_io(cur_kind);
    s1      = active && status[1];
    s0      = active && status[0];
    rd_n    = !(is_rd && (state == TS_T2));
    wr_n    = !(is_wr && (state == TS_T2));
    decode  = (state == TS_T4);
    done    = (state == TS_T4) || ((state == TS_T3) && (cur_kind != K_FETCH));
    if (state == TS_T1) begin
      ad_oe  = 1'b1;
      ad_out = cur_addr[DATA_W-1:0];
    end else if (is_wr && data_phase) begin
      ad_oe  = 1'b1;
      ad_out = cur_wdata;
    end else begin
      ad_oe  = 1'b0;
      ad_out = '0;
    end
  end

endmodule

// File: rtl/mcs_capture.sv
module mcs_capture
  import mcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state,
  input  kind_e             cur_kind,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] data_reg,
  output logic [DATA_W-1:0] instr_reg
);

  logic dr_en, ir_en;

  assign dr_en = (state == TS_T2) && kind_reads(cur_kind);
  assign ir_en = (state == TS_T3) && (cur_kind == K_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_reg <= '0;
    else if (dr_en) data_reg <= ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     instr_reg <= '0;
    else if (ir_en) instr_reg <= data_reg;
  end

endmodule

// File: rtl/mcs_bus_seq.sv
module mcs_bus_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int RST_SYNC = 2,
  localparam int HI_W    = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              busy,
  output logic              done,
  output logic              decode,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic [DATA_W-1:0] data_reg,
  output logic [DATA_W-1:0] instr_reg
);

  logic              rst_int_n;
  tstate_e           state;
  kind_e             cur_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  mcs_reset_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  mcs_tstate_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .state(state), .cur_kind(cur_kind),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  mcs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state(state), .cur_kind(cur_kind),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .busy(busy), .done(done), .decode(decode),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .io_m(io_m), .s1(s1), .s0(s0)
  );

  mcs_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_int_n),
    .state(state), .cur_kind(cur_kind), .ad_in(ad_in),
    .data_reg(data_reg), .instr_reg(instr_reg)
  );

endmodule

// File: rtl/mcs_bus_seq_chk.sv
module mcs_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic decode,
  input logic ad_oe,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic s1,
  input logic s0
);

  // R2
  busy_starts_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ale);

  // R3
  ale_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R3
  ale_drives_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe && rd_n && wr_n);

  // R6
  read_pins_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R6
  rd_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> rd_n);

  // R7
  wr_data_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> ad_oe && wr_n);

  // R7
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R5
  status_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (s1 || s0));

  // R10
  decode_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decode |-> done);

  // R11
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind mcs_bus_seq mcs_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .decode(decode),
  .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .s1(s1), .s0(s0)
);

// File: tb/tb_mcs_bus_seq.sv
module tb_mcs_bus_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  ad_in = 8'h5A;
  logic        busy, done, decode, ad_oe, ale, rd_n, wr_n, io_m, s1, s0;
  logic [7:0]  addr_hi, ad_out, data_reg, instr_reg;

  always #4 clk = ~clk;

  mcs_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
    .busy(busy), .done(done), .decode(decode), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .io_m(io_m), .s1(s1), .s0(s0), .data_reg(data_reg), .instr_reg(instr_reg)
  );

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  bit ended = 0;

  // ---------------- reference model ----------------
  int       m_t = 0;      // 0 idle, 1..4 = T1..T4
  int       m_kind = 0;
  bit [15:0] m_addr = 0;
  bit [7:0]  m_wd = 0, m_dr = 0, m_ir = 0;
  int        m_sync = 0;

  function automatic bit k_rd(int k); return k == 0 || k == 1 || k == 3; endfunction
  function automatic bit k_wr(int k); return k == 2 || k == 4; endfunction

  always @(posedge clk) begin
    cyc++;
    ad_in <= ad_in * 8'd5 + 8'd3;
    if (!rst_n || m_sync < 2) begin
      m_t = 0; m_kind = 0; m_addr = 0; m_wd = 0; m_dr = 0; m_ir = 0;
    end else begin
      case (m_t)
        0: if (req_valid && req_kind <= 3'd4) begin
             m_t = 1; m_kind = int'(req_kind); m_addr = req_addr; m_wd = req_wdata;
           end
        1: m_t = 2;
        2: begin if (k_rd(m_kind)) m_dr = ad_in; m_t = 3; end
        3: begin
             if (m_kind == 0) begin m_ir = m_dr; m_t = 4; end
             else m_t = 0;
           end
        default: m_t = 0;
      endcase
    end
    if (!rst_n) m_sync = 0;
    else if (m_sync < 2) m_sync++;
  end

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  function automatic string tg(string t);
    return (m_t == 0 && (!rst_n || m_sync < 2)) ? "R1" : t;
  endfunction

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!ended) begin
      bit act, rd, wr, oe;
      int st;
      act = (m_t != 0);
      rd  = k_rd(m_kind);
      wr  = k_wr(m_kind);
      oe  = (m_t == 1) || (wr && (m_t == 2 || m_t == 3));
      st  = !act ? 0 : (m_kind == 0) ? 3 : rd ? 2 : 1;
      chk(tg("R2"),  "busy",    busy, act);
      chk(tg("R3"),  "ale",     ale, m_t == 1);
      chk(tg("R3"),  "addr_hi", addr_hi, act ? m_addr[15:8] : 0);
      chk(tg("R4"),  "ad_oe",   ad_oe, oe);
      chk(tg("R4"),  "ad_out",  ad_out, (m_t == 1) ? m_addr[7:0] : oe ? m_wd : 0);
      chk(tg("R5"),  "io_m",    io_m, act && (m_kind == 3 || m_kind == 4));
      chk(tg("R5"),  "status",  {s1, s0}, st);
      chk(tg("R6"),  "rd_n",    rd_n, !(rd && m_t == 2));
      chk(tg("R7"),  "wr_n",    wr_n, !(wr && m_t == 2));
      chk(tg("R8"),  "data_reg", data_reg, m_dr);
      chk(tg("R9"),  "instr_reg", instr_reg, m_ir);
      chk(tg("R10"), "decode",  decode, m_t == 4);
      chk(tg("R11"), "done",    done, m_t == 4 || (m_t == 3 && m_kind != 0));
    end
  end

  task automatic summary();
    ended = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 5000 && !ended) begin
      total++; fails++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      summary();
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic issue(int k, bit [15:0] a, bit [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(k); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = 16'h0; req_wdata = 8'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: request during the reset-sync window must not start a cycle
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h1234;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    issue(0, 16'h2050, 8'h00);   // opcode fetch
    issue(1, 16'hA0C4, 8'h00);   // memory read
    issue(2, 16'h4F11, 8'h9E);   // memory write
    issue(3, 16'h0081, 8'h00);   // I/O read
    issue(4, 16'h00FE, 8'h3C);   // I/O write
    issue(0, 16'hFFFF, 8'h00);   // second fetch, new opcode
    issue(2, 16'h0000, 8'hFF);   // write: instr_reg must hold

    // R12: illegal kinds start nothing
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'hBEEF; req_wdata = 8'h77;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12", "busy after illegal kind", busy, 0);
      chk("R12", "ale after illegal kind", ale, 0);
    end

    // R2: request held high through busy cycles; back-to-back acceptance
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd3; req_addr = 16'h0042;
    @(negedge clk);
    req_kind = 3'd0; req_addr = 16'h7777;   // ignored while busy
    repeat (3) @(negedge clk);
    repeat (8) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule